// File: doc/BRIEF.md
# Chained Core/Auxiliary Timer Pair

This block pairs a core up/down timer that owns an overflow toggle latch with an auxiliary up/down timer. The core timer steps on a prescaled clock enable, steps on that enable only while a gate input is high, or steps on selected edges of its own input pin. Each time it wraps, up past its maximum or down past zero, the toggle latch flips.

The auxiliary timer has two modes. In counter mode it steps on selected edges of either its own input pin or the toggle latch. Taking both edges of the latch chains the two timers into a count twice the core width. Taking one edge gives one more bit, because the latch acts as the extra bit in the middle. The two timers count in directions chosen independently. In reload mode the auxiliary timer holds its value and copies it into the core timer on each selected trigger.

Preset strobes load either timer with a value. The counters and the latch are registers and drive the outputs directly.

Top module: `chained_timer_pair`

## Requirements
- R1: After a synchronous reset, `core_cnt`, `aux_cnt` and `tgl_out` are all zero.
- R2: The core timer steps only while `core_run` is 1. With `core_mode` 00 it steps once per cycle with `prescale_en` high. With 01 it also needs `gate_in` high. With 10 it steps on edges of `core_pin` chosen by `core_edge`: 01 rising, 10 falling, 11 either edge, 00 none. It counts down when `core_dn` is 1 and up otherwise.
- R3: `tgl_out` flips exactly when the core timer wraps, up from all-ones to zero or down from zero to all-ones.
- R4: With `aux_mode` 001 and `aux_run` 1, the auxiliary timer steps once per selected event. With `aux_sel` 111, any edge of the toggle latch is an event, so the auxiliary timer steps once per core wrap.
- R5: With `aux_sel` 110 the event is a falling edge of the latch, and with 101 a rising edge. Either way the auxiliary timer steps on every second core wrap.
- R6: `aux_dn` sets the auxiliary direction independently of `core_dn` while the timers are chained.
- R7: `aux_sel` 001, 010 and 011 select rising, falling and either edge of `aux_pin`. `aux_sel` 000 and 100 select no event, and the auxiliary timer then stays still.
- R8: With `aux_mode` 100, each selected event copies `aux_cnt` into the core timer.
- R9: With `aux_mode` 100 the auxiliary timer never steps, whatever `aux_run` is.
- R10: When a reload and a core step fall in the same cycle, the core timer takes the reloaded value and the step is dropped.
- R11: `ld_core` and `ld_aux` load `ld_value` into their timer on the next edge. This overrides stepping and reload, and it leaves `tgl_out` unchanged.
- R12: Pin edges are found after a two-stage synchronizer. Each selected edge of a pin or of the latch gives exactly one step or reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale_en | input | 1 | Prescaled count enable for the core timer |
| gate_in | input | 1 | Gate level for the core gated mode |
| core_pin | input | 1 | Count input pin for the core timer |
| aux_pin | input | 1 | Count/trigger input pin for the auxiliary timer |
| core_mode | input | 2 | Core mode: 00 timer, 01 gated, 10 pin counter |
| core_run | input | 1 | Core run flag |
| core_dn | input | 1 | Core direction, 1 = down |
| core_edge | input | 2 | Core pin edge select |
| aux_mode | input | 3 | Auxiliary mode: 001 counter, 100 reload, others stopped |
| aux_run | input | 1 | Auxiliary run flag (counter mode) |
| aux_dn | input | 1 | Auxiliary direction, 1 = down |
| aux_sel | input | 3 | Auxiliary event select |
| ld_core | input | 1 | Preset strobe for the core timer |
| ld_aux | input | 1 | Preset strobe for the auxiliary timer |
| ld_value | input | W | Preset value |
| core_cnt | output | W | Core timer value |
| aux_cnt | output | W | Auxiliary timer value |
| tgl_out | output | 1 | Overflow toggle latch |

## Verification
A reload of the core timer and an ordinary core step can land on the same edge. The bench sets this up in two ways. In the first, the core timer runs on every cycle while a rising edge on `aux_pin` triggers a reload. In the second, the core timer wraps and its own toggle edge triggers the reload one cycle later. The core value is sampled right after the reload edge and must equal the auxiliary value exactly, not that value plus one.

// File: rtl/ctp_pkg.sv
package ctp_pkg;
  typedef enum logic [1:0] {
    CORE_TIMER = 2'b00,
    CORE_GATED = 2'b01,
    CORE_COUNT = 2'b10
  } core_mode_e;

  localparam logic [2:0] AUX_COUNT  = 3'b001;
  localparam logic [2:0] AUX_RELOAD = 3'b100;

  // Event select: x01/x10/x11 on pin (msb 0) or latch (msb 1)
  function automatic logic edge_hit(input logic [2:0] sel,
                                    input logic pin_now, input logic pin_old,
                                    input logic tgl_now, input logic tgl_old);
    logic now_v, old_v;
    now_v = sel[2] ? tgl_now : pin_now;
    old_v = sel[2] ? tgl_old : pin_old;
    unique case (sel[1:0])
      2'b01:   edge_hit = now_v & ~old_v;
      2'b10:   edge_hit = ~now_v & old_v;
      2'b11:   edge_hit = now_v ^ old_v;
      default: edge_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/ctp_trig.sv
module ctp_trig (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic       tgl,
  input  logic [2:0] sel,
  output logic       hit
);
  import ctp_pkg::*;

  logic pin_s1, pin_s2, pin_d, tgl_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_s1 <= 1'b0;
      pin_s2 <= 1'b0;
      pin_d  <= 1'b0;
      tgl_d  <= 1'b0;
    end else begin
      pin_s1 <= pin;
      pin_s2 <= pin_s1;
      pin_d  <= pin_s2;
      tgl_d  <= tgl;
    end
  end

  assign hit = edge_hit(sel, pin_s2, pin_d, tgl, tgl_d);
endmodule

// File: rtl/ctp_counter.sv
module ctp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  input  logic         dn,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  assign wrap = step && !ld && (dn ? (cnt == '0) : (cnt == MAXV));

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (ld)   cnt <= ld_val;
    else if (step) cnt <= dn ? cnt - ONE : cnt + ONE;
  end
endmodule

// File: rtl/chained_timer_pair.sv
module chained_timer_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         prescale_en,
  input  logic         gate_in,
  input  logic         core_pin,
  input  logic         aux_pin,
  input  logic [1:0]   core_mode,
  input  logic         core_run,
  input  logic         core_dn,
  input  logic [1:0]   core_edge,
  input  logic [2:0]   aux_mode,
  input  logic         aux_run,
  input  logic         aux_dn,
  input  logic [2:0]   aux_sel,
  input  logic         ld_core,
  input  logic         ld_aux,
  input  logic [W-1:0] ld_value,
  output logic [W-1:0] core_cnt,
  output logic [W-1:0] aux_cnt,
  output logic         tgl_out
);
  import ctp_pkg::*;

  localparam int NTRIG = 2;  // 0: core pin, 1: aux pin / latch

  logic [NTRIG-1:0] trig_pin, trig_tgl, trig_hit;
  logic [2:0]       trig_sel [NTRIG];

  assign trig_pin = {aux_pin, core_pin};
  assign trig_tgl = {tgl_out, 1'b0};
  assign trig_sel[0] = {1'b0, core_edge};
  assign trig_sel[1] = aux_sel;

  for (genvar i = 0; i < NTRIG; i++) begin : g_trig
    ctp_trig u_trig (
      .clk (clk),
      .rst (rst),
      .pin (trig_pin[i]),
      .tgl (trig_tgl[i]),
      .sel (trig_sel[i]),
      .hit (trig_hit[i])
    );
  end

  logic core_step, core_ld, core_wrap, reload;
  logic aux_step, aux_wrap;
  logic [W-1:0] core_ld_val;

  always_comb begin
    core_step = 1'b0;
    if (core_run) begin
      unique case (core_mode_e'(core_mode))
        CORE_TIMER: core_step = prescale_en;
        CORE_GATED: core_step = prescale_en & gate_in;
        CORE_COUNT: core_step = trig_hit[0];
        default:    core_step = 1'b0;
      endcase
    end
  end

  assign reload      = (aux_mode == AUX_RELOAD) && trig_hit[1];
  assign core_ld     = ld_core || reload;
  assign core_ld_val = ld_core ? ld_value : aux_cnt;
  assign aux_step    = (aux_mode == AUX_COUNT) && aux_run && trig_hit[1];

  ctp_counter #(.W(W)) u_core (
    .clk (clk), .rst (rst), .ld (core_ld), .ld_val (core_ld_val),
    .step (core_step), .dn (core_dn), .cnt (core_cnt), .wrap (core_wrap)
  );

  ctp_counter #(.W(W)) u_aux (
    .clk (clk), .rst (rst), .ld (ld_aux), .ld_val (ld_value),
    .step (aux_step), .dn (aux_dn), .cnt (aux_cnt), .wrap (aux_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)            tgl_out <= 1'b0;
    else if (core_wrap) tgl_out <= ~tgl_out;
  end

  logic unused_ok;
  assign unused_ok = aux_wrap;
endmodule

// File: rtl/ctp_checker.sv
module ctp_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         core_run,
  input logic [2:0]   aux_mode,
  input logic [2:0]   aux_sel,
  input logic         ld_core,
  input logic         ld_aux,
  input logic [W-1:0] ld_value,
  input logic [W-1:0] core_cnt,
  input logic [W-1:0] aux_cnt,
  input logic         tgl_out
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  // R1
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (core_cnt == '0 && aux_cnt == '0 && !tgl_out));

  // R3
  p_tgl_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && tgl_out != $past(tgl_out)) |->
      ((core_cnt == '0 && $past(core_cnt) == MAXV) ||
       (core_cnt == MAXV && $past(core_cnt) == '0)));

  // R9
  p_reload_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (aux_mode == 3'b100 && !ld_aux) |=> $stable(aux_cnt));

  // R7
  p_no_event_r7: assert property (@(posedge clk) disable iff (rst)
    ((aux_sel == 3'b000 || aux_sel == 3'b100) && !ld_aux) |=> $stable(aux_cnt));

  // R2
  p_core_stop_r2: assert property (@(posedge clk) disable iff (rst)
    (!core_run && !ld_core && aux_mode != 3'b100) |=> $stable(core_cnt));

  // R11
  p_load_core_r11: assert property (@(posedge clk) disable iff (rst)
    ld_core |=> (core_cnt == $past(ld_value) && $stable(tgl_out)));

  p_load_aux_r11: assert property (@(posedge clk) disable iff (rst)
    ld_aux |=> (aux_cnt == $past(ld_value)));
endmodule

bind chained_timer_pair ctp_checker #(.W(W)) u_chk (
  .clk (clk), .rst (rst), .core_run (core_run), .aux_mode (aux_mode),
  .aux_sel (aux_sel), .ld_core (ld_core), .ld_aux (ld_aux),
  .ld_value (ld_value), .core_cnt (core_cnt), .aux_cnt (aux_cnt),
  .tgl_out (tgl_out)
);

// File: tb/test_chained_timer_pair.sv
`timescale 1ns/1ps
module test_chained_timer_pair;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prescale_en = 1'b0, gate_in = 1'b0, core_pin = 1'b0, aux_pin = 1'b0;
  logic [1:0] core_mode = 2'b00, core_edge = 2'b00;
  logic core_run = 1'b0, core_dn = 1'b0, aux_run = 1'b0, aux_dn = 1'b0;
  logic [2:0] aux_mode = 3'b000, aux_sel = 3'b000;
  logic ld_core = 1'b0, ld_aux = 1'b0;
  logic [W-1:0] ld_value = '0;
  logic [W-1:0] core_cnt, aux_cnt;
  logic tgl_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chained_timer_pair #(.W(W)) i_chained_timer_pair (
    .clk, .rst, .prescale_en, .gate_in, .core_pin, .aux_pin, .core_mode,
    .core_run, .core_dn, .core_edge, .aux_mode, .aux_run, .aux_dn, .aux_sel,
    .ld_core, .ld_aux, .ld_value, .core_cnt, .aux_cnt, .tgl_out
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; core_run = 1'b0; aux_run = 1'b0; prescale_en = 1'b0;
    gate_in = 1'b0; core_pin = 1'b0; aux_pin = 1'b0; core_dn = 1'b0;
    aux_dn = 1'b0; core_mode = 2'b00; core_edge = 2'b00;
    aux_mode = 3'b000; aux_sel = 3'b000;
    clocks(4);
    rst = 1'b0;
  endtask

  task automatic run_core(input int n);
    core_run = 1'b1; prescale_en = 1'b1;
    clocks(n);
    core_run = 1'b0; prescale_en = 1'b0;
    clocks(4);
  endtask

  task automatic toggle_pin(input bit aux, input int n);
    for (int i = 0; i < n; i++) begin
      if (aux) aux_pin = ~aux_pin; else core_pin = ~core_pin;
      clocks(4);
    end
  endtask

  task automatic load(input bit aux, input int v);
    ld_value = W'(v);
    if (aux) ld_aux = 1'b1; else ld_core = 1'b1;
    clocks(1);
    ld_aux = 1'b0; ld_core = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 core", core_cnt, 0);
    check("R1 aux", aux_cnt, 0);
    check("R1 tgl", tgl_out, 0);
  endtask

  // 56 steps of a 4-bit core: 3 wraps, core ends at 8
  task automatic t_chain(input logic [2:0] sel, input bit adn, input int exp_aux,
                         input string tag);
    do_reset();
    aux_mode = 3'b001; aux_run = 1'b1; aux_sel = sel; aux_dn = adn;
    run_core(56);
    check({tag, " core"}, core_cnt, 8);
    check({tag, " aux"}, aux_cnt, exp_aux);
    check({tag, " tgl R3"}, tgl_out, 1);
  endtask

  task automatic t_core_down();
    do_reset();
    core_dn = 1'b1; aux_mode = 3'b001; aux_run = 1'b1; aux_sel = 3'b111;
    run_core(56);  // wraps at steps 1,17,33,49
    check("R6 core down", core_cnt, 8);
    check("R6 aux up", aux_cnt, 4);
    check("R3 tgl even", tgl_out, 0);
  endtask

  task automatic t_gated();
    do_reset();
    core_mode = 2'b01; gate_in = 1'b0;
    run_core(10);
    check("R2 gate low", core_cnt, 0);
    gate_in = 1'b1;
    run_core(10);
    check("R2 gate high", core_cnt, 10);
  endtask

  task automatic t_core_pin();
    do_reset();
    core_mode = 2'b10; core_edge = 2'b01; core_run = 1'b1;
    toggle_pin(1'b0, 6);
    check("R2 R12 core pin rise", core_cnt, 3);
    core_edge = 2'b11;
    toggle_pin(1'b0, 4);
    check("R2 core pin any", core_cnt, 7);
    core_edge = 2'b00;
    toggle_pin(1'b0, 4);
    check("R2 core pin none", core_cnt, 7);
  endtask

  task automatic t_aux_pin();
    do_reset();
    aux_mode = 3'b001; aux_run = 1'b1; aux_sel = 3'b010;
    toggle_pin(1'b1, 6);
    check("R7 aux pin fall", aux_cnt, 3);
    aux_sel = 3'b011;
    toggle_pin(1'b1, 2);
    check("R7 aux pin any", aux_cnt, 5);
    aux_sel = 3'b000;
    toggle_pin(1'b1, 4);
    check("R7 aux sel none", aux_cnt, 5);
    aux_sel = 3'b001; aux_run = 1'b0;
    toggle_pin(1'b1, 4);
    check("R4 aux run off", aux_cnt, 5);
  endtask

  task automatic t_load();
    do_reset();
    load(1'b0, 14);
    check("R11 core load", core_cnt, 14);
    load(1'b1, 6);
    check("R11 aux load", aux_cnt, 6);
    check("R11 tgl kept", tgl_out, 0);
  endtask

  task automatic t_reload_pin();
    do_reset();
    load(1'b1, 9);
    aux_mode = 3'b100; aux_sel = 3'b001; aux_run = 1'b1;
    core_run = 1'b1; prescale_en = 1'b1;
    aux_pin = 1'b1;
    for (int i = 0; i < 3; i++) @(posedge clk);
    @(negedge clk);
    check("R8 R10 pin reload beats step", core_cnt, 9);
    clocks(2);
    check("R8 counting after reload", core_cnt, 11);
    core_run = 1'b0; prescale_en = 1'b0;
    toggle_pin(1'b1, 3);
    check("R9 aux holds in reload", aux_cnt, 9);
  endtask

  task automatic t_reload_tgl();
    do_reset();
    load(1'b1, 5);
    aux_mode = 3'b100; aux_sel = 3'b111; aux_run = 1'b1;
    core_run = 1'b1; prescale_en = 1'b1;
    ld_value = W'(14); ld_core = 1'b1;
    @(posedge clk); @(negedge clk);
    ld_core = 1'b0;
    for (int i = 0; i < 3; i++) @(posedge clk);
    @(negedge clk);
    check("R8 R10 latch reload", core_cnt, 5);
    check("R9 aux unchanged", aux_cnt, 5);
    core_run = 1'b0; prescale_en = 1'b0;
    clocks(2);
  endtask

  initial begin
    t_reset();
    t_chain(3'b111, 1'b0, 3, "R4 any edge 32-bit");
    t_chain(3'b110, 1'b0, 1, "R5 falling 33-bit");
    t_chain(3'b101, 1'b0, 2, "R5 rising 33-bit");
    t_chain(3'b111, 1'b1, 13, "R6 aux down");
    t_chain(3'b100, 1'b0, 0, "R7 latch none");
    t_core_down();
    t_gated();
    t_core_pin();
    t_aux_pin();
    t_load();
    t_reload_pin();
    t_reload_tgl();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule